// File: doc/BRIEF.md
# Inherent Register Operation Unit

This unit executes the one-byte register instructions of a small 8-bit accumulator processor, the ones that take no operand bytes. It holds two 8-bit accumulators (A and B), a 16-bit index register (X), a 16-bit stack pointer (SP) and a five-bit condition code set: half carry H, negative N, zero Z, overflow V and carry C. When `op_valid` is high on a clock edge, the unit decodes `op_code` and updates its registers and flags at that same edge. In the following cycle it pulses `done_o` for an implemented opcode, or `illegal_o` for one of the unassigned codes in its range.

The unit handles four groups of work. The accumulator group subtracts, compares, adds and copies between A and B. The pointer group moves values between SP and X with a fixed offset of one, and steps SP up or down. Codes that other units own produce no pulse and leave all state alone. These include the decimal adjust, push and pull, return and interrupt codes, and any code outside the two pages 0x10–0x1F and 0x30–0x3F.

A debug write port lets the surrounding logic or a testbench preset any register. The register outputs are always visible.

Top module: `inh_exec_unit`

## Requirements
- R1: After reset, A, B, X and SP are zero, all flags are zero, and `done_o` and `illegal_o` are low.
- R2: Opcode 0x10 writes A−B (mod 256) into A. It sets N from bit 7 and Z when the result is zero. It sets V on signed overflow and sets C when B > A unsigned. The incoming carry is not used. H and B are unchanged.
- R3: Opcode 0x11 sets N, Z, V and C exactly as 0x10 does, but leaves A, B and H unchanged.
- R4: Opcode 0x1B writes A+B (mod 256) into A. H is the carry out of bit 3 and C is the carry out of bit 7. V is set on signed overflow, and N and Z come from the result.
- R5: Opcode 0x16 copies A into B, and opcode 0x17 copies B into A. Each sets N and Z from the moved byte, clears V, and keeps H and C.
- R6: Opcode 0x30 loads X with SP+1, and opcode 0x35 loads SP with X−1, both modulo 2^16. No flag changes.
- R7: Opcode 0x31 adds one to SP and opcode 0x34 subtracts one from SP, wrapping modulo 2^16. No flag changes.
- R8: The following codes raise `illegal_o` and change no register or flag: 0x12, 0x13, 0x14, 0x15, 0x18, 0x1A, 0x1C, 0x1D, 0x1E, 0x1F, 0x38, 0x3A, 0x3C and 0x3D.
- R9: `done_o` (implemented code) or `illegal_o` (illegal code) is high for exactly the one cycle after the accepting edge, and the two are never high together. A strobe may be given on every cycle, and each one gets its own pulse.
- R10: Any other opcode produces no pulse and changes no state.
- R11: With `dbg_we` high and `op_valid` low, `dbg_wdata` is written at the edge into the target chosen by `dbg_sel`: 0 = A (low byte), 1 = B (low byte), 2 = X, 3 = SP, 4 = flags (bits 4..0 = H,N,Z,V,C). A debug write in the same cycle as a strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Opcode to execute |
| dbg_we | input | 1 | Debug write enable |
| dbg_sel | input | 3 | Debug target select |
| dbg_wdata | input | 16 | Debug write data |
| acc_a_o | output | 8 | Accumulator A |
| acc_b_o | output | 8 | Accumulator B |
| idx_o | output | 16 | Index register X |
| stk_o | output | 16 | Stack pointer |
| flags_o | output | 5 | Flags {H,N,Z,V,C} |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Illegal-opcode pulse |

## Verification
The assertions assume that `op_code`, `op_valid`, `dbg_we` and `dbg_sel` carry known values whenever reset is released, and that reset is asserted from time zero. The stimulus meets this by driving every input to a defined level at time zero and changing inputs only on falling clock edges. Both the strobe and the debug write last exactly one cycle, except in the deliberate back-to-back and collision cases. Register and flag states are preset through the debug port before each operation, so every check starts from a state the bench has chosen.

// File: rtl/iru_pkg.sv
package iru_pkg;
  localparam int OPC_W = 8;
  localparam int CCR_W = 5;

  typedef enum logic [3:0] {
    K_NONE, K_ILL, K_SUB, K_CMP, K_ADD, K_TAB, K_TBA,
    K_TSX, K_INS, K_DES, K_TXS
  } op_kind_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  localparam logic [2:0] SEL_A   = 3'd0;
  localparam logic [2:0] SEL_B   = 3'd1;
  localparam logic [2:0] SEL_X   = 3'd2;
  localparam logic [2:0] SEL_SP  = 3'd3;
  localparam logic [2:0] SEL_CCR = 3'd4;
endpackage

// File: rtl/iru_decode.sv
module iru_decode
  import iru_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output op_kind_e         kind
);
  always_comb begin
    case (opc)
      8'h10: kind = K_SUB;
      8'h11: kind = K_CMP;
      8'h1B: kind = K_ADD;
      8'h16: kind = K_TAB;
      8'h17: kind = K_TBA;
      8'h30: kind = K_TSX;
      8'h31: kind = K_INS;
      8'h34: kind = K_DES;
      8'h35: kind = K_TXS;
      8'h12, 8'h13, 8'h14, 8'h15, 8'h18, 8'h1A,
      8'h1C, 8'h1D, 8'h1E, 8'h1F,
      8'h38, 8'h3A, 8'h3C, 8'h3D: kind = K_ILL;
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/iru_alu8.sv
module iru_alu8
  import iru_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_kind_e      kind,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  ccr_t          ccr_in,
  output logic [DW-1:0] a_nxt,
  output logic [DW-1:0] b_nxt,
  output ccr_t          ccr_nxt
);
  localparam int HB = DW / 2;

  logic [DW:0]   sum;
  logic [DW:0]   diff;
  logic [HB:0]   half;
  logic [DW-1:0] moved;

  assign sum   = {1'b0, a} + {1'b0, b};
  assign diff  = {1'b0, a} - {1'b0, b};
  assign half  = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]};
  assign moved = (kind == K_TAB) ? a : b;

  always_comb begin
    a_nxt   = a;
    b_nxt   = b;
    ccr_nxt = ccr_in;
    case (kind)
      K_SUB, K_CMP: begin
        if (kind == K_SUB) a_nxt = diff[DW-1:0];
        ccr_nxt.n = diff[DW-1];
        ccr_nxt.z = (diff[DW-1:0] == '0);
        ccr_nxt.v = (a[DW-1] ^ b[DW-1]) & (diff[DW-1] ^ a[DW-1]);
        ccr_nxt.c = diff[DW];
      end
      K_ADD: begin
        a_nxt     = sum[DW-1:0];
        ccr_nxt.h = half[HB];
        ccr_nxt.n = sum[DW-1];
        ccr_nxt.z = (sum[DW-1:0] == '0);
        ccr_nxt.v = ~(a[DW-1] ^ b[DW-1]) & (sum[DW-1] ^ a[DW-1]);
        ccr_nxt.c = sum[DW];
      end
      K_TAB, K_TBA: begin
        if (kind == K_TAB) b_nxt = moved;
        else               a_nxt = moved;
        ccr_nxt.n = moved[DW-1];
        ccr_nxt.z = (moved == '0);
        ccr_nxt.v = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/iru_ptr16.sv
module iru_ptr16
  import iru_pkg::*;
#(
  parameter int PW = 16
) (
  input  op_kind_e      kind,
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] sp,
  output logic [PW-1:0] x_nxt,
  output logic [PW-1:0] sp_nxt
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] sp_up;
  logic [PW-1:0] sp_dn;
  logic [PW-1:0] x_dn;

  assign sp_up = sp + ONE;
  assign sp_dn = sp - ONE;
  assign x_dn  = x - ONE;

  always_comb begin
    x_nxt  = x;
    sp_nxt = sp;
    case (kind)
      K_TSX: x_nxt  = sp_up;
      K_INS: sp_nxt = sp_up;
      K_DES: sp_nxt = sp_dn;
      K_TXS: sp_nxt = x_dn;
      default: ;
    endcase
  end
endmodule

// File: rtl/inh_exec_unit.sv
module inh_exec_unit
  import iru_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  input  logic             dbg_we,
  input  logic [2:0]       dbg_sel,
  input  logic [PW-1:0]    dbg_wdata,
  output logic [DW-1:0]    acc_a_o,
  output logic [DW-1:0]    acc_b_o,
  output logic [PW-1:0]    idx_o,
  output logic [PW-1:0]    stk_o,
  output logic [CCR_W-1:0] flags_o,
  output logic             done_o,
  output logic             illegal_o
);
  logic [DW-1:0] a_q, b_q, a_d, b_d, a_alu, b_alu;
  logic [PW-1:0] x_q, sp_q, x_d, sp_d, x_ptr, sp_ptr;
  ccr_t          ccr_q, ccr_d, ccr_alu;
  logic          done_d, ill_d, reg_en;
  op_kind_e      kind, kind_g;

  iru_decode u_dec (.opc(op_code), .kind(kind));

  assign kind_g = op_valid ? kind : K_NONE;

  iru_alu8 #(.DW(DW)) u_alu (
    .kind(kind_g), .a(a_q), .b(b_q), .ccr_in(ccr_q),
    .a_nxt(a_alu), .b_nxt(b_alu), .ccr_nxt(ccr_alu)
  );

  iru_ptr16 #(.PW(PW)) u_ptr (
    .kind(kind_g), .x(x_q), .sp(sp_q), .x_nxt(x_ptr), .sp_nxt(sp_ptr)
  );

  assign reg_en = op_valid | dbg_we;

  always_comb begin
    a_d   = a_alu;
    b_d   = b_alu;
    x_d   = x_ptr;
    sp_d  = sp_ptr;
    ccr_d = ccr_alu;
    if (!op_valid && dbg_we) begin
      case (dbg_sel)
        SEL_A:   a_d   = dbg_wdata[DW-1:0];
        SEL_B:   b_d   = dbg_wdata[DW-1:0];
        SEL_X:   x_d   = dbg_wdata;
        SEL_SP:  sp_d  = dbg_wdata;
        SEL_CCR: ccr_d = ccr_t'(dbg_wdata[CCR_W-1:0]);
        default: ;
      endcase
    end
    done_d = op_valid && (kind != K_NONE) && (kind != K_ILL);
    ill_d  = op_valid && (kind == K_ILL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      x_q   <= '0;
      sp_q  <= '0;
      ccr_q <= '0;
    end else if (reg_en) begin
      a_q   <= a_d;
      b_q   <= b_d;
      x_q   <= x_d;
      sp_q  <= sp_d;
      ccr_q <= ccr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= done_d;
      illegal_o <= ill_d;
    end
  end

  assign acc_a_o = a_q;
  assign acc_b_o = b_q;
  assign idx_o   = x_q;
  assign stk_o   = sp_q;
  assign flags_o = ccr_q;
endmodule

// File: rtl/iru_chk.sv
module iru_chk
  import iru_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [OPC_W-1:0] op_code,
  input logic [DW-1:0]    acc_a_o,
  input logic [DW-1:0]    acc_b_o,
  input logic [PW-1:0]    idx_o,
  input logic [PW-1:0]    stk_o,
  input logic [CCR_W-1:0] flags_o,
  input logic             done_o,
  input logic             illegal_o
);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, illegal_o}));

  a_r9_add_done: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 8'h1B |=> done_o);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(acc_a_o) && $stable(acc_b_o) && $stable(idx_o)
                  && $stable(stk_o) && $stable(flags_o));

  a_r3_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 8'h11 |=> $stable(acc_a_o) && $stable(acc_b_o));

  a_r6_ptr_flags: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == 8'h30 || op_code == 8'h35 ||
                 op_code == 8'h31 || op_code == 8'h34) |=> $stable(flags_o));

  a_r7_ins_step: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 8'h31 |=> stk_o == PW'($past(stk_o) + PW'(1)));

  a_r10_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code[7:4] != 4'h1 && op_code[7:4] != 4'h3 |=> !done_o && !illegal_o);
endmodule

bind inh_exec_unit iru_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .idx_o(idx_o), .stk_o(stk_o),
  .flags_o(flags_o), .done_o(done_o), .illegal_o(illegal_o)
);

// File: tb/tb_inh_exec_unit.sv
`timescale 1ns/1ps
module tb_inh_exec_unit;
  localparam int DW = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [7:0]    op_code = 8'h00;
  logic          dbg_we = 1'b0;
  logic [2:0]    dbg_sel = 3'd0;
  logic [15:0]   dbg_wdata = 16'h0;
  logic [7:0]    acc_a_o, acc_b_o;
  logic [15:0]   idx_o, stk_o;
  logic [4:0]    flags_o;
  logic          done_o, illegal_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  inh_exec_unit #(.DW(DW), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dbg_we(dbg_we), .dbg_sel(dbg_sel), .dbg_wdata(dbg_wdata),
    .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .idx_o(idx_o), .stk_o(stk_o),
    .flags_o(flags_o), .done_o(done_o), .illegal_o(illegal_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] val);
    @(negedge clk);
    dbg_we = 1'b1; dbg_sel = sel; dbg_wdata = val; op_valid = 1'b0;
  endtask

  task automatic preset(input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] x, input logic [15:0] sp,
                        input logic [4:0] f);
    wr(3'd0, {8'h0, a}); wr(3'd1, {8'h0, b}); wr(3'd2, x);
    wr(3'd3, sp); wr(3'd4, {11'h0, f});
  endtask

  task automatic run_op(input logic [7:0] op);
    @(negedge clk);
    dbg_we = 1'b0; op_valid = 1'b1; op_code = op;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  function automatic logic [4:0] f_sub(input int a, input int b, input logic [4:0] f);
    int r;
    r = (a - b) & 255;
    return {f[4], r[7], r == 0, ((a ^ b) & (a ^ r) & 128) != 0, b > a};
  endfunction

  function automatic logic [4:0] f_add(input int a, input int b);
    int r;
    r = (a + b) & 255;
    return {((a & 15) + (b & 15)) > 15, r[7], r == 0,
            ((~(a ^ b)) & (a ^ r) & 128) != 0, (a + b) > 255};
  endfunction

  function automatic logic [4:0] f_mov(input int v, input logic [4:0] f);
    return {f[4], v[7], v == 0, 1'b0, f[0]};
  endfunction

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    logic [4:0] f;
    logic [7:0] ill_list [14];
    logic [7:0] foreign [8];
    ill_list = '{8'h12, 8'h13, 8'h14, 8'h15, 8'h18, 8'h1A, 8'h1C,
                 8'h1D, 8'h1E, 8'h1F, 8'h38, 8'h3A, 8'h3C, 8'h3D};
    foreign  = '{8'h19, 8'h32, 8'h36, 8'h3F, 8'h00, 8'h20, 8'h4F, 8'hFF};

    repeat (3) @(negedge clk);
    // R1 reset state
    check(acc_a_o == 0 && acc_b_o == 0 && idx_o == 0 && stk_o == 0 && flags_o == 0,
          "R1", "regs after reset", {acc_a_o, acc_b_o, 11'h0, flags_o}, 0);
    check(!done_o && !illegal_o, "R1", "pulses after reset", {done_o, illegal_o}, 0);
    rst_n = 1'b1;

    // R11 debug writes to every target
    preset(8'hA5, 8'h5A, 16'h1234, 16'hBEEF, 5'h15);
    @(negedge clk); dbg_we = 1'b0;
    check(acc_a_o == 8'hA5 && acc_b_o == 8'h5A, "R11", "debug acc",
          {acc_a_o, acc_b_o}, 32'hA55A);
    check(idx_o == 16'h1234 && stk_o == 16'hBEEF && flags_o == 5'h15, "R11",
          "debug ptr/flags", {idx_o, stk_o}, 32'h1234BEEF);

    // R2 R3 R4 sweep: all A against sixteen B values
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 16; j++) begin
        int bb;
        bb = j * 17;
        f = 5'((i + j) & 31);
        wr(3'd0, 16'(i)); wr(3'd1, 16'(bb)); wr(3'd4, {11'h0, f});
        run_op(8'h10);
        check(done_o && acc_a_o == 8'((i - bb) & 255) && acc_b_o == 8'(bb)
              && flags_o == f_sub(i, bb, f), "R2", "SUB",
              {done_o, acc_a_o, flags_o}, {1'b1, 8'((i - bb) & 255), f_sub(i, bb, f)});
        wr(3'd0, 16'(i)); wr(3'd4, {11'h0, f});
        run_op(8'h11);
        check(done_o && acc_a_o == 8'(i) && acc_b_o == 8'(bb)
              && flags_o == f_sub(i, bb, f), "R3", "CMP",
              {done_o, acc_a_o, flags_o}, {1'b1, 8'(i), f_sub(i, bb, f)});
        run_op(8'h1B);
        check(done_o && acc_a_o == 8'((i + bb) & 255) && acc_b_o == 8'(bb)
              && flags_o == f_add(i, bb), "R4", "ADD",
              {done_o, acc_a_o, flags_o}, {1'b1, 8'((i + bb) & 255), f_add(i, bb)});
      end
    end

    // R5 accumulator transfers
    for (int i = 0; i < 256; i += 5) begin
      f = 5'(i & 31);
      preset(8'(i), 8'h3C, 16'h0, 16'h0, f);
      run_op(8'h16);
      check(done_o && acc_b_o == 8'(i) && acc_a_o == 8'(i) && flags_o == f_mov(i, f),
            "R5", "TAB", {acc_b_o, flags_o}, {8'(i), f_mov(i, f)});
      wr(3'd1, 16'(255 - i)); wr(3'd4, {11'h0, ~f});
      run_op(8'h17);
      check(done_o && acc_a_o == 8'(255 - i) && flags_o == f_mov(255 - i, ~f),
            "R5", "TBA", {acc_a_o, flags_o}, {8'(255 - i), f_mov(255 - i, ~f)});
    end

    // R6 stack/index transfers with wrap
    preset(8'h0, 8'h0, 16'h5555, 16'hFFFF, 5'h1F);
    run_op(8'h30);
    check(done_o && idx_o == 16'h0000 && stk_o == 16'hFFFF && flags_o == 5'h1F,
          "R6", "TSX wrap", {idx_o, 11'h0, flags_o}, {16'h0, 16'h1F});
    wr(3'd3, 16'h1234); wr(3'd4, 16'h0A);
    run_op(8'h30);
    check(idx_o == 16'h1235 && flags_o == 5'h0A, "R6", "TSX", idx_o, 16'h1235);
    wr(3'd2, 16'h0000);
    run_op(8'h35);
    check(done_o && stk_o == 16'hFFFF && idx_o == 0 && flags_o == 5'h0A,
          "R6", "TXS wrap", stk_o, 16'hFFFF);
    wr(3'd2, 16'h8000);
    run_op(8'h35);
    check(stk_o == 16'h7FFF, "R6", "TXS", stk_o, 16'h7FFF);

    // R7 stack pointer step with wrap
    wr(3'd3, 16'hFFFF); wr(3'd4, 16'h11);
    run_op(8'h31);
    check(done_o && stk_o == 16'h0000 && flags_o == 5'h11, "R7", "INS wrap", stk_o, 0);
    run_op(8'h34);
    check(done_o && stk_o == 16'hFFFF && flags_o == 5'h11, "R7", "DES wrap", stk_o, 16'hFFFF);
    for (int k = 0; k < 8; k++) run_op(8'h34);
    check(stk_o == 16'hFFF7, "R7", "DES x8", stk_o, 16'hFFF7);

    // R8 illegal codes
    foreach (ill_list[k]) begin
      preset(8'h81, 8'h7E, 16'hC0DE, 16'h4321, 5'h0B);
      run_op(ill_list[k]);
      check(illegal_o && !done_o, "R8", "illegal pulse", {ill_list[k], illegal_o}, {ill_list[k], 1'b1});
      check(acc_a_o == 8'h81 && acc_b_o == 8'h7E && idx_o == 16'hC0DE &&
            stk_o == 16'h4321 && flags_o == 5'h0B, "R8", "state kept",
            {acc_a_o, acc_b_o, 11'h0, flags_o}, {16'h817E, 16'h000B});
    end

    // R10 codes owned elsewhere
    foreach (foreign[k]) begin
      preset(8'h42, 8'h24, 16'h1111, 16'h2222, 5'h1C);
      run_op(foreign[k]);
      check(!illegal_o && !done_o, "R10", "no pulse", {foreign[k], done_o, illegal_o}, {foreign[k], 2'b0});
      check(acc_a_o == 8'h42 && acc_b_o == 8'h24 && idx_o == 16'h1111 &&
            stk_o == 16'h2222 && flags_o == 5'h1C, "R10", "state kept",
            {acc_a_o, acc_b_o, 11'h0, flags_o}, {16'h4224, 16'h001C});
    end

    // R9 back-to-back strobes and single-cycle pulses
    preset(8'd5, 8'd3, 16'h0, 16'h0, 5'h0);
    @(negedge clk); dbg_we = 1'b0; op_valid = 1'b1; op_code = 8'h1B;
    @(negedge clk); op_code = 8'h12;
    check(done_o && !illegal_o && acc_a_o == 8'd8, "R9", "first of pair",
          {done_o, illegal_o, acc_a_o}, {2'b10, 8'd8});
    @(negedge clk); op_code = 8'h1B;
    check(illegal_o && !done_o && acc_a_o == 8'd8, "R9", "illegal in train",
          {done_o, illegal_o, acc_a_o}, {2'b01, 8'd8});
    @(negedge clk); op_valid = 1'b0;
    check(done_o && !illegal_o && acc_a_o == 8'd11, "R9", "third of train",
          {done_o, illegal_o, acc_a_o}, {2'b10, 8'd11});
    @(negedge clk);
    check(!done_o && !illegal_o, "R9", "pulse ends", {done_o, illegal_o}, 0);

    // R11 debug write dropped on collision with a strobe
    preset(8'h01, 8'h02, 16'h0, 16'h0, 5'h0);
    @(negedge clk);
    op_valid = 1'b1; op_code = 8'h16; dbg_we = 1'b1; dbg_sel = 3'd0; dbg_wdata = 16'h0077;
    @(negedge clk);
    op_valid = 1'b0; dbg_we = 1'b0;
    check(acc_a_o == 8'h01 && acc_b_o == 8'h01 && done_o, "R11", "collision",
          {acc_a_o, acc_b_o}, 16'h0101);

    snap = 0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule